// File: doc/BRIEF.md
# Sum-to-Radix-4 Booth Digit Recoder

This block takes two two's-complement operands of equal width and produces the radix-4 Booth digits of their sum directly. It never forms the binary sum first. A chain of per-digit cells does the work, built from ordinary half and full adders plus signed-bit adders whose sum or carry carries a negative weight. Each cell consumes two bits of each operand and two carries from the cell below, and it emits one digit. Each cell also hands two carries upward. Because each carry crosses only one cell boundary, no carry runs along the whole width.

Each digit leaves the block as a sign/magnitude code, with a sign flag and magnitude flags. The same digit is also given as a 4-bit signed integer for debug and checking. The digit count is ceil(W/2). An odd width closes with a top digit from a doubly-negative full adder, which stays in the Booth set. An even width closes with a wider signed top digit in -4..+4 and adds no extra sign-extension digit. A parameter selects whether the outputs are registered.

Top module: `sum_booth_recoder`

## Requirements
- R1: The weighted sum over j of digit_j·4^j, read from `dig_val` with digit j in bits [4j+3:4j], equals the signed value of A+B.
- R2: Every digit below the top one, and the top digit for odd W, lies in {-2,-1,0,+1,+2}. `dig_one` and `dig_two` are never both high for such a digit.
- R3: The code value, (-1)^neg·(one + 2·two + 4·quad), equals `dig_val` for each digit. `quad` is `top_quad` for the top digit and 0 for all others.
- R4: A zero digit has `dig_neg`, `dig_one` and `dig_two` all low.
- R5: For odd W, `top_quad` is always low.
- R6: For even W, the top digit lies in -4..+4. Magnitude 3 is shown as one and two together with quad low. Magnitude 4 is shown as quad alone.
- R7: With REG_OUT=1, the outputs show the operands sampled at the previous rising clock edge and do not change between edges.
- R8: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_in | input | W | Operand A, two's complement |
| b_in | input | W | Operand B, two's complement |
| dig_neg | output | ND | Per-digit sign flag, 1 for a negative digit |
| dig_one | output | ND | Per-digit magnitude-1 flag |
| dig_two | output | ND | Per-digit magnitude-2 flag |
| top_quad | output | 1 | Magnitude-4 flag of the top digit, even W only |
| dig_val | output | 4·ND | Per-digit signed integer value, digit j in bits [4j+3:4j] |

## Verification
The riskiest coincidence is two carries landing in the top digit in the same cycle as the top digit's own negatively weighted operand bits. The two carries are the plain half-adder carry and the signed-bit carry from the cell below. This is provoked by full operand sweeps at one even and one odd width, and by directed extreme pairs: both operands at the most negative value, both at the most positive value, and -1 plus 0. At these points the top digit reaches -4, +4 or a cancelling zero. Each case is judged at the ports: the weighted digit sum must equal A+B, the code and the integer view must agree, and each digit must stay in its permitted range.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef logic signed [3:0] sbr_digit_t;

  typedef struct packed {
    logic c;
    logic s;
  } add2_t;

  // plain half adder: 2c + s = p + q
  function automatic add2_t ha_plain(input logic p, input logic q);
    add2_t r;
    r.s = p ^ q;
    r.c = p & q;
    return r;
  endfunction

  // plain full adder: 2c + s = p + q + ci
  function automatic add2_t fa_plain(input logic p, input logic q, input logic ci);
    add2_t r;
    r.s = p ^ q ^ ci;
    r.c = (p & q) | (ci & (p | q));
    return r;
  endfunction

  // signed half adder, sum weighted negative: 2c - s = p + q
  function automatic add2_t ha_negsum(input logic p, input logic q);
    add2_t r;
    r.s = p ^ q;
    r.c = p | q;
    return r;
  endfunction

  // doubly-negative full adder: -2c + s = -p - q + ci
  function automatic add2_t fa_negpq(input logic p, input logic q, input logic ci);
    add2_t r;
    r.s = p ^ q ^ ci;
    r.c = (p & q) | (~ci & (p | q));
    return r;
  endfunction

  function automatic sbr_digit_t bit_val(input logic b);
    return $signed({3'b000, b});
  endfunction

  // regular digit: -2*s_hi + s_lo + c_in
  function automatic sbr_digit_t cell_value(input logic s_hi, input logic s_lo,
                                            input logic c_in);
    return bit_val(s_lo) + bit_val(c_in) - $signed({2'b00, s_hi, 1'b0});
  endfunction

  function automatic logic [3:0] digit_mag(input sbr_digit_t v);
    return (v < 0) ? 4'(-v) : 4'(v);
  endfunction

  function automatic logic code_neg(input sbr_digit_t v);
    return v < 0;
  endfunction

  function automatic logic code_one(input sbr_digit_t v);
    return digit_mag(v) == 4'd1 || digit_mag(v) == 4'd3;
  endfunction

  function automatic logic code_two(input sbr_digit_t v);
    return digit_mag(v) == 4'd2 || digit_mag(v) == 4'd3;
  endfunction

  function automatic logic code_quad(input sbr_digit_t v);
    return digit_mag(v) == 4'd4;
  endfunction

endpackage

// File: rtl/sbr_cell.sv
module sbr_cell
  import sbr_pkg::*;
(
  input  logic       a_lo,
  input  logic       a_hi,
  input  logic       b_lo,
  input  logic       b_hi,
  input  logic       c1_in,
  input  logic       c2_in,
  output logic       c1_out,
  output logic       c2_out,
  output sbr_digit_t digit
);
  add2_t lo_fa;
  add2_t hi_ha;
  add2_t mix_ha;
  logic  s_lo;
  logic  s_hi_neg;

  always_comb begin
    lo_fa    = fa_plain(a_lo, b_lo, c1_in);
    hi_ha    = ha_plain(a_hi, b_hi);
    mix_ha   = ha_negsum(lo_fa.c, hi_ha.s);
    s_lo     = lo_fa.s;
    s_hi_neg = mix_ha.s;
  end

  assign c1_out = hi_ha.c;
  assign c2_out = mix_ha.c;
  assign digit  = cell_value(s_hi_neg, s_lo, c2_in);
endmodule

// File: rtl/sbr_msd_odd.sv
module sbr_msd_odd
  import sbr_pkg::*;
(
  input  logic       a_top,
  input  logic       b_top,
  input  logic       c1_in,
  input  logic       c2_in,
  output sbr_digit_t digit
);
  add2_t top_fa;

  assign top_fa = fa_negpq(a_top, b_top, c1_in);
  // -2*carry + sum + second chain carry
  assign digit  = cell_value(top_fa.c, top_fa.s, c2_in);
endmodule

// File: rtl/sbr_msd_even.sv
module sbr_msd_even
  import sbr_pkg::*;
(
  input  logic       a_lo,
  input  logic       a_hi,
  input  logic       b_lo,
  input  logic       b_hi,
  input  logic       c1_in,
  input  logic       c2_in,
  output sbr_digit_t digit
);
  add2_t lo_fa;
  add2_t hi_fa;

  always_comb begin
    lo_fa = fa_plain(a_lo, b_lo, c1_in);
    hi_fa = fa_negpq(a_hi, b_hi, lo_fa.c);
  end

  // s_lo + c2 + 2*s' - 4*c'
  assign digit = bit_val(lo_fa.s) + bit_val(c2_in)
               + $signed({2'b00, hi_fa.s, 1'b0})
               - $signed({1'b0, hi_fa.c, 2'b00});
endmodule

// File: rtl/sbr_outreg.sv
module sbr_outreg #(
  parameter int WIDTH = 8,
  parameter bit REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/sum_booth_recoder.sv
module sum_booth_recoder
  import sbr_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int ND     = (W + 1) / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  output logic [ND-1:0]   dig_neg,
  output logic [ND-1:0]   dig_one,
  output logic [ND-1:0]   dig_two,
  output logic            top_quad,
  output logic [4*ND-1:0] dig_val
);
  localparam bit ODD  = (W % 2) == 1;
  localparam int NREG = ODD ? W / 2 : W / 2 - 1;
  localparam int OW   = 7 * ND + 1;

  logic [NREG:0]   c1_chain;
  logic [NREG:0]   c2_chain;
  sbr_digit_t      dig_raw [ND];
  logic [ND-1:0]   comb_neg, comb_one, comb_two;
  logic [4*ND-1:0] comb_val;
  logic            comb_quad;
  logic [OW-1:0]   comb_bus, reg_bus;

  assign c1_chain[0] = 1'b0;
  assign c2_chain[0] = 1'b0;

  generate
    for (genvar j = 0; j < NREG; j++) begin : g_cell
      sbr_cell u_cell (
        .a_lo   (a_in[2*j]),
        .a_hi   (a_in[2*j+1]),
        .b_lo   (b_in[2*j]),
        .b_hi   (b_in[2*j+1]),
        .c1_in  (c1_chain[j]),
        .c2_in  (c2_chain[j]),
        .c1_out (c1_chain[j+1]),
        .c2_out (c2_chain[j+1]),
        .digit  (dig_raw[j])
      );
    end

    if (ODD) begin : g_top_odd
      sbr_msd_odd u_msd (
        .a_top (a_in[W-1]),
        .b_top (b_in[W-1]),
        .c1_in (c1_chain[NREG]),
        .c2_in (c2_chain[NREG]),
        .digit (dig_raw[ND-1])
      );
    end else begin : g_top_even
      sbr_msd_even u_msd (
        .a_lo  (a_in[W-2]),
        .a_hi  (a_in[W-1]),
        .b_lo  (b_in[W-2]),
        .b_hi  (b_in[W-1]),
        .c1_in (c1_chain[NREG]),
        .c2_in (c2_chain[NREG]),
        .digit (dig_raw[ND-1])
      );
    end
  endgenerate

  always_comb begin
    for (int j = 0; j < ND; j++) begin
      comb_neg[j]       = code_neg(dig_raw[j]);
      comb_one[j]       = code_one(dig_raw[j]);
      comb_two[j]       = code_two(dig_raw[j]);
      comb_val[4*j +: 4] = dig_raw[j];
    end
    comb_quad = code_quad(dig_raw[ND-1]);
  end

  assign comb_bus = {comb_quad, comb_neg, comb_one, comb_two, comb_val};

  sbr_outreg #(.WIDTH(OW), .REG(REG_OUT)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comb_bus),
    .q     (reg_bus)
  );

  assign {top_quad, dig_neg, dig_one, dig_two, dig_val} = reg_bus;
endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int ND     = (W + 1) / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    a_in,
  input logic [W-1:0]    b_in,
  input logic [ND-1:0]   dig_neg,
  input logic [ND-1:0]   dig_one,
  input logic [ND-1:0]   dig_two,
  input logic            top_quad,
  input logic [4*ND-1:0] dig_val
);
  localparam bit ODD = (W % 2) == 1;

  logic signed [63:0] in_sum, out_sum;
  logic primed;

  always_comb begin
    in_sum  = 64'($signed(a_in)) + 64'($signed(b_in));
    out_sum = '0;
    for (int j = 0; j < ND; j++)
      out_sum = out_sum + (64'($signed(dig_val[4*j +: 4])) <<< (2 * j));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_seq
      // R1, R7: value of the digits equals the sum sampled one edge earlier
      p_sum_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> out_sum == $past(in_sum));
      // R8
      p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst_n)
        dig_val == '0 && dig_neg == '0 && dig_one == '0 && dig_two == '0 && !top_quad);
    end else begin : g_comb
      p_sum_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_sum == in_sum);
    end

    for (genvar j = 0; j < ND; j++) begin : g_dig
      logic signed [3:0] v;
      logic signed [3:0] dec;
      logic              q;
      assign v   = $signed(dig_val[4*j +: 4]);
      assign q   = (j == ND - 1) ? top_quad : 1'b0;
      assign dec = dig_neg[j]
                 ? -($signed({3'b000, dig_one[j]}) + $signed({2'b00, dig_two[j], 1'b0})
                     + $signed({1'b0, q, 2'b00}))
                 :  ($signed({3'b000, dig_one[j]}) + $signed({2'b00, dig_two[j], 1'b0})
                     + $signed({1'b0, q, 2'b00}));

      p_code_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec == v);
      p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v == 4'sd0 |-> !dig_neg[j] && !dig_one[j] && !dig_two[j]);

      if (j < ND - 1 || ODD) begin : g_booth
        p_booth_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
          v >= -4'sd2 && v <= 4'sd2 && !(dig_one[j] && dig_two[j]));
      end else begin : g_wide
        p_top_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
          v >= -4'sd4 && v <= 4'sd4 && !(top_quad && (dig_one[j] || dig_two[j])));
      end
    end

    if (ODD) begin : g_odd_quad
      p_no_quad_r5: assert property (@(posedge clk) disable iff (!rst_n) !top_quad);
    end
  endgenerate
endmodule

bind sum_booth_recoder sbr_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_sum_booth_recoder.sv
module sim_sum_booth_recoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;

  // {a, b, expected digits d3..d0 as signed nibbles}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 16'h0000},
    {8'h01, 8'h01, 16'h001E},
    {8'h80, 8'h80, 16'hC000},
    {8'h7F, 8'h7F, 16'h400E},
    {8'h05, 8'hFD, 16'h001E},
    {8'hFF, 8'h00, 16'h000F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [6:0]  a7 = '0, b7 = '0;
  logic [3:0]  n8, o8, t8, n7, o7, t7;
  logic        q8, q7;
  logic [15:0] v8, v7;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sum_booth_recoder #(.W(8), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a8), .b_in(b8),
    .dig_neg(n8), .dig_one(o8), .dig_two(t8), .top_quad(q8), .dig_val(v8));

  sum_booth_recoder #(.W(7), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .a_in(a7), .b_in(b7),
    .dig_neg(n7), .dig_one(o7), .dig_two(t7), .top_quad(q7), .dig_val(v7));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint dsum(input logic [15:0] v);
    longint s = 0;
    for (int j = 0; j < 4; j++) s += longint'($signed(v[4*j +: 4])) * (longint'(1) << (2*j));
    return s;
  endfunction

  function automatic longint code_int(input logic n, input logic o, input logic t, input logic q);
    longint m = (o ? 1 : 0) + (t ? 2 : 0) + (q ? 4 : 0);
    return n ? -m : m;
  endfunction

  function automatic longint csum(input logic [3:0] n, input logic [3:0] o,
                                  input logic [3:0] t, input logic q);
    longint s = 0;
    for (int j = 0; j < 4; j++)
      s += code_int(n[j], o[j], t[j], (j == 3) ? q : 1'b0) * (longint'(1) << (2*j));
    return s;
  endfunction

  // digit range/shape checks shared by both widths; top_wide selects R6 vs R5
  task automatic shape(input logic [3:0] n, input logic [3:0] o, input logic [3:0] t,
                       input logic q, input logic [15:0] v, input bit top_wide);
    bit ok2 = 1, ok4 = 1, okt = 1;
    for (int j = 0; j < 4; j++) begin
      longint d = longint'($signed(v[4*j +: 4]));
      if (d == 0 && (n[j] || o[j] || t[j])) ok4 = 0;
      if (j < 3 || !top_wide) begin
        if (d < -2 || d > 2 || (o[j] && t[j])) ok2 = 0;
      end
    end
    chk(ok2, "R2 booth digit set", longint'(v), 0);
    chk(ok4, "R4 zero digit code low", longint'({n, o, t}), 0);
    if (top_wide) begin
      longint d3 = longint'($signed(v[15:12]));
      if (d3 < -4 || d3 > 4) okt = 0;
      if ((d3 == 3 || d3 == -3) && !(o[3] && t[3] && !q)) okt = 0;
      if ((d3 == 4 || d3 == -4) && !(q && !o[3] && !t[3])) okt = 0;
      chk(okt, "R6 wide top digit", d3, 0);
    end else begin
      chk(!q, "R5 odd top quad low", longint'(q), 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    a8 = 8'h55; b8 = 8'h3C; a7 = 7'h2A; b7 = 7'h13;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero in reset despite nonzero operands
    chk(v8 == '0 && n8 == '0 && o8 == '0 && t8 == '0 && !q8, "R8 reset clear W8",
        longint'(v8), 0);
    chk(v7 == '0 && n7 == '0 && o7 == '0 && t7 == '0 && !q7, "R8 reset clear W7",
        longint'(v7), 0);
    rst_n = 1'b1;

    // table of directed vectors, exact digits (R1, R3)
    for (int i = 0; i < NVEC; i++) begin
      a8 = VEC[i][31:24];
      b8 = VEC[i][23:16];
      @(negedge clk);
      chk(v8 == VEC[i][15:0], "R1 exact digits", longint'(v8), longint'(VEC[i][15:0]));
      chk(csum(n8, o8, t8, q8) == dsum(v8), "R3 code matches value",
          csum(n8, o8, t8, q8), dsum(v8));
    end

    // R7: output holds until the next rising edge
    a8 = 8'h00; b8 = 8'h00;
    @(negedge clk);
    a8 = 8'h01; b8 = 8'h01;
    #2;
    chk(v8 == 16'h0000, "R7 no change before edge", longint'(v8), 0);
    @(negedge clk);
    chk(v8 == 16'h001E, "R7 update after edge", longint'(v8), 16'h001E);

    // odd-width corner: both operands most negative gives top digit -2 (R5, R1)
    a7 = 7'h40; b7 = 7'h40;
    @(negedge clk);
    chk(dsum(v7) == -128 && $signed(v7[15:12]) == -4'sd2 && n7[3] && o7[3] == 0 && t7[3],
        "R5 odd top digit -2", dsum(v7), -128);

    // even width sweep
    for (int i = 0; i < 65536; i++) begin
      longint exp;
      a8 = i[7:0];
      b8 = i[15:8];
      exp = longint'($signed(a8)) + longint'($signed(b8));
      @(negedge clk);
      chk(dsum(v8) == exp, "R1 digit sum W8", dsum(v8), exp);
      chk(csum(n8, o8, t8, q8) == exp, "R3 code sum W8", csum(n8, o8, t8, q8), exp);
      shape(n8, o8, t8, q8, v8, 1'b1);
    end

    // odd width sweep
    for (int i = 0; i < 16384; i++) begin
      longint exp;
      a7 = i[6:0];
      b7 = i[13:7];
      exp = longint'($signed(a7)) + longint'($signed(b7));
      @(negedge clk);
      chk(dsum(v7) == exp, "R1 digit sum W7", dsum(v7), exp);
      chk(csum(n7, o7, t7, q7) == exp, "R3 code sum W7", csum(n7, o7, t7, q7), exp);
      shape(n7, o7, t7, q7, v7, 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule